// File: doc/BRIEF.md
# Multi-CPU Doorbell Interrupt Unit

This block holds, for each CPU of a cluster, a 32-bit doorbell cause register and a 32-bit doorbell enable register. It raises two summary interrupt lines per CPU toward the interrupt controller. Software on any CPU, or an inbound message-signalled write from the I/O fabric, rings doorbells by writing one shared trigger register. That write names a doorbell number and a bitmap of target CPUs, and the named cause bit is set in every selected CPU at once.

A CPU acknowledges doorbells by writing its own cause register. Each bit written as zero is cleared and each bit written as one is kept, so writing the complement of a single bit clears only that bit. A mode pin sets how the 32 doorbells are split between the two summary lines. In inter-processor mode, doorbells 7:0 feed the low line and doorbells 31:16 feed the high line. In full-message mode, doorbells 15:0 feed the low line and 31:16 feed the high line.

The register port is a plain single-cycle port and takes a write or a read in every cycle. It has no back-pressure. The message port is a plain write strobe with data and is also accepted in every cycle. The two ports may be active in the same cycle.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every cause and enable register is zero, every summary line is low, and `reg_rdata` is zero.
- R2: A register-port write to offset 0x4, or a message-port write, takes the doorbell number from data bits 4:0 and the CPU bitmap from bit 8 upward (bit 8+c selects CPU c). On the next clock edge the numbered cause bit is set in every selected CPU. Unselected CPUs are unchanged.
- R3: A register-port write to offset 0x8 by CPU `reg_cpu` clears each of that CPU's cause bits whose data bit is 0 and keeps each bit whose data bit is 1. Other CPUs are unaffected.
- R4: A register-port write to offset 0xC by CPU `reg_cpu` replaces that CPU's enable register. An enable bit of 1 lets the matching doorbell reach a summary line, and an enable bit of 0 blocks it.
- R5: A register-port read (`reg_re`) of offset 0x8 or 0xC returns `reg_cpu`'s cause or enable register on `reg_rdata` after the next clock edge. Any other offset reads as zero.
- R6: With `mode_full_msi`=0, `sum_lo[c]` is high when any of bits 7:0 is both pending and enabled for CPU c, and `sum_hi[c]` is high for bits 31:16. Bits 15:8 drive neither line.
- R7: With `mode_full_msi`=1, `sum_lo[c]` covers bits 15:0 and `sum_hi[c]` covers bits 31:16.
- R8: The summary lines follow the registers without an extra register stage. They change in the same cycle as the cause or enable update, which is one edge after the write.
- R9: If a trigger and a cause-clearing write address the same cause bit in the same cycle, the bit ends up set.
- R10: A register-port trigger and a message-port trigger in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_full_msi | input | 1 | 0: inter-processor split, 1: full-message split |
| reg_we | input | 1 | Register-port write strobe |
| reg_re | input | 1 | Register-port read strobe |
| reg_cpu | input | CPU_W | CPU issuing the register access |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one edge after `reg_re` |
| msi_we | input | 1 | Inbound message write strobe (to the trigger register) |
| msi_data | input | 32 | Inbound message write data |
| sum_lo | output | NUM_CPUS | Low-group summary interrupt per CPU |
| sum_hi | output | NUM_CPUS | High-group summary interrupt per CPU |

## Verification
Two functions can land on the same cause bit in the same cycle. The first is a trigger arriving on the message port. The second is an acknowledge write on the register port whose data holds zeros. The bench provokes this by driving both strobes at one falling edge for the same CPU and doorbell, then reading the cause register back. The collided bit must be set and every other zero-written bit must be clear. A second case drives both trigger sources together, and the result must hold the union of both doorbells.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int BELLS = 32;
  localparam int BELL_W = 5;
  localparam int MAP_LSB = 8;
  localparam logic [3:0] OFF_TRIG  = 4'h4;
  localparam logic [3:0] OFF_CAUSE = 4'h8;
  localparam logic [3:0] OFF_MASK  = 4'hC;

  function automatic logic [BELLS-1:0] lo_group(input logic full_msi);
    return full_msi ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  function automatic logic [BELLS-1:0] hi_group();
    return 32'hFFFF_0000;
  endfunction
endpackage

// File: rtl/db_trigger_decode.sv
module db_trigger_decode
  import db_pkg::*;
#(
  parameter int NUM_CPUS = 2
) (
  input  logic                           cpu_trig,
  input  logic [BELLS-1:0]               cpu_data,
  input  logic                           msi_trig,
  input  logic [BELLS-1:0]               msi_data,
  output logic [NUM_CPUS-1:0][BELLS-1:0] set_vec
);
  logic [BELLS-1:0] cpu_onehot, msi_onehot;

  assign cpu_onehot = 32'd1 << cpu_data[BELL_W-1:0];
  assign msi_onehot = 32'd1 << msi_data[BELL_W-1:0];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [BELLS-1:0] from_cpu, from_msi;
    assign from_cpu = (cpu_trig && cpu_data[MAP_LSB+c]) ? cpu_onehot : '0;
    assign from_msi = (msi_trig && msi_data[MAP_LSB+c]) ? msi_onehot : '0;
    assign set_vec[c] = from_cpu | from_msi;
  end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
  import db_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BELLS-1:0] set_bits,
  input  logic             clr_we,
  input  logic [BELLS-1:0] clr_data,
  input  logic             mask_we,
  input  logic [BELLS-1:0] mask_data,
  output logic [BELLS-1:0] cause_q,
  output logic [BELLS-1:0] mask_q
);
  logic [BELLS-1:0] kept;

  assign kept = clr_we ? (cause_q & clr_data) : cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= kept | set_bits;
      if (mask_we) mask_q <= mask_data;
    end
  end

  AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((cause_q & $past(set_bits)) == $past(set_bits))); // R9

  AST_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(cause_q) & ~cause_q) & ~($past(clr_we) ? ~$past(clr_data) : '0)) == '0)); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R4
endmodule

// File: rtl/db_summary.sv
module db_summary
  import db_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_msi,
  input  logic [BELLS-1:0] cause,
  input  logic [BELLS-1:0] mask,
  output logic             lo,
  output logic             hi
);
  logic [BELLS-1:0] live;

  assign live = cause & mask;
  assign lo = |(live & lo_group(full_msi));
  assign hi = |(live & hi_group());

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (!lo && !hi)); // R4

  AST_MID_BELLS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_msi && (cause[7:0] & mask[7:0]) == '0) |-> !lo); // R6
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import db_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_full_msi,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [CPU_W-1:0]    reg_cpu,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                msi_we,
  input  logic [31:0]         msi_data,
  output logic [NUM_CPUS-1:0] sum_lo,
  output logic [NUM_CPUS-1:0] sum_hi
);
  logic [NUM_CPUS-1:0][BELLS-1:0] set_vec;
  logic [NUM_CPUS-1:0][BELLS-1:0] cause_all;
  logic [NUM_CPUS-1:0][BELLS-1:0] mask_all;
  logic                           trig_we;
  logic [31:0]                    rd_next;

  assign trig_we = reg_we && (reg_addr == OFF_TRIG);

  db_trigger_decode #(.NUM_CPUS(NUM_CPUS)) u_decode (
    .cpu_trig (trig_we),
    .cpu_data (reg_wdata),
    .msi_trig (msi_we),
    .msi_data (msi_data),
    .set_vec  (set_vec)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic own;
    assign own = (reg_cpu == CPU_W'(c));

    db_cpu_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_bits  (set_vec[c]),
      .clr_we    (reg_we && own && (reg_addr == OFF_CAUSE)),
      .clr_data  (reg_wdata),
      .mask_we   (reg_we && own && (reg_addr == OFF_MASK)),
      .mask_data (reg_wdata),
      .cause_q   (cause_all[c]),
      .mask_q    (mask_all[c])
    );

    db_summary u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .full_msi (mode_full_msi),
      .cause    (cause_all[c]),
      .mask     (mask_all[c]),
      .lo       (sum_lo[c]),
      .hi       (sum_hi[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (reg_re) begin
      if (reg_addr == OFF_CAUSE) rd_next = cause_all[reg_cpu];
      else if (reg_addr == OFF_MASK) rd_next = mask_all[reg_cpu];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !reg_we && reg_addr == OFF_MASK) |=> (reg_rdata == $past(mask_all[reg_cpu]))); // R5

  AST_READ_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr != OFF_MASK && reg_addr != OFF_CAUSE) |=> (reg_rdata == '0)); // R5
endmodule

// File: tb/doorbell_unit_bench.sv
module doorbell_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_full_msi = 0;
  logic        reg_we = 0, reg_re = 0;
  logic [0:0]  reg_cpu = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        msi_we = 0;
  logic [31:0] msi_data = 0;
  logic [NCPU-1:0] sum_lo, sum_hi;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_unit #(.NUM_CPUS(NCPU)) u_doorbell_unit (
    .clk(clk), .rst_n(rst_n), .mode_full_msi(mode_full_msi),
    .reg_we(reg_we), .reg_re(reg_re), .reg_cpu(reg_cpu), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msi_we(msi_we), .msi_data(msi_data), .sum_lo(sum_lo), .sum_hi(sum_hi)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    reg_we = 0; reg_re = 0; msi_we = 0;
  endtask

  task automatic wr(input logic c, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_cpu = c; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic msi(input logic [31:0] d);
    @(negedge clk);
    msi_we = 1; msi_data = d;
    step();
  endtask

  task automatic rd(input logic c, input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_re = 1; reg_cpu = c; reg_addr = a;
    step();
    v = reg_rdata;
  endtask

  function automatic logic [31:0] trig(input logic [1:0] map, input int bell);
    return (32'(map) << 8) | 32'(bell);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 sum_lo", 32'(sum_lo), 0);
    chk("R1 sum_hi", 32'(sum_hi), 0);
    chk("R1 rdata", reg_rdata, 0);
    for (int c = 0; c < NCPU; c++) begin
      rd(c[0], 4'h8, v); chk("R1 cause", v, 0);
      rd(c[0], 4'hC, v); chk("R1 mask", v, 0);
    end
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(0, 4'h4, trig(2'b10, 5));
    rd(1, 4'h8, v); chk("R2 selected cpu1", v, 32'h20);
    rd(0, 4'h8, v); chk("R2 unselected cpu0", v, 0);
    msi(trig(2'b11, 31));
    rd(0, 4'h8, v); chk("R2 msi cpu0", v, 32'h8000_0000);
    rd(1, 4'h8, v); chk("R2 msi cpu1", v, 32'h8000_0020);
    wr(0, 4'h8, 0); wr(1, 4'h8, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    msi(trig(2'b10, 5)); msi(trig(2'b10, 6));
    wr(1, 4'h8, ~32'h20);
    rd(1, 4'h8, v); chk("R3 complement clears one", v, 32'h40);
    wr(0, 4'h8, 0);
    rd(1, 4'h8, v); chk("R3 other cpu untouched", v, 32'h40);
    wr(1, 4'h8, 0);
    rd(1, 4'h8, v); chk("R3 zero clears all", v, 0);
  endtask

  task automatic t_mask_read();
    logic [31:0] v;
    wr(0, 4'hC, 32'hFFFF_FFFF);
    rd(0, 4'hC, v); chk("R4 mask cpu0", v, 32'hFFFF_FFFF);
    rd(1, 4'hC, v); chk("R4 mask cpu1 untouched", v, 0);
    rd(0, 4'h0, v); chk("R5 other offset", v, 0);
    rd(0, 4'h4, v); chk("R5 trigger offset", v, 0);
  endtask

  task automatic t_modes();
    mode_full_msi = 0;
    msi(trig(2'b01, 10));
    chk("R6 bell10 lo ipi", 32'(sum_lo[0]), 0);
    chk("R6 bell10 hi ipi", 32'(sum_hi[0]), 0);
    mode_full_msi = 1; #1;
    chk("R7 bell10 lo full", 32'(sum_lo[0]), 1);
    mode_full_msi = 0;
    wr(0, 4'h8, 0);
    msi(trig(2'b01, 2));
    chk("R8 lo same cycle", 32'(sum_lo[0]), 1);
    chk("R6 cpu1 no lo", 32'(sum_lo[1]), 0);
    msi(trig(2'b01, 20));
    chk("R6 hi bell20", 32'(sum_hi[0]), 1);
    mode_full_msi = 1; #1;
    chk("R7 hi bell20", 32'(sum_hi[0]), 1);
    mode_full_msi = 0;
    wr(0, 4'hC, 0);
    chk("R4 mask off lo", 32'(sum_lo[0]), 0);
    chk("R4 mask off hi", 32'(sum_hi[0]), 0);
    wr(0, 4'h8, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    msi(trig(2'b10, 7));
    @(negedge clk);
    msi_we = 1; msi_data = trig(2'b10, 7);
    reg_we = 1; reg_cpu = 1; reg_addr = 4'h8; reg_wdata = 0;
    step();
    rd(1, 4'h8, v); chk("R9 same bit trigger wins", v, 32'h80);
    @(negedge clk);
    msi_we = 1; msi_data = trig(2'b10, 9);
    reg_we = 1; reg_cpu = 1; reg_addr = 4'h8; reg_wdata = 0;
    step();
    rd(1, 4'h8, v); chk("R9 other bit cleared new set", v, 32'h200);
    wr(1, 4'h8, 0);
  endtask

  task automatic t_dual();
    logic [31:0] v;
    @(negedge clk);
    reg_we = 1; reg_cpu = 1; reg_addr = 4'h4; reg_wdata = trig(2'b01, 1);
    msi_we = 1; msi_data = trig(2'b01, 30);
    step();
    rd(0, 4'h8, v); chk("R10 both triggers", v, 32'h4000_0002);
    rd(1, 4'h8, v); chk("R10 cpu1 untouched", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_trigger();
    t_clear();
    t_mask_read();
    t_modes();
    t_collision();
    t_dual();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule